// File: doc/BRIEF.md
# SPI Flash Command Sequencer with Shared Byte Buffer

This block is an SPI master for flash command transactions, controlled through a simple byte-wide register bus. Software writes an opcode into a dedicated register, sets how many data bytes go out and how many come back, loads the outgoing bytes into a shared byte buffer, and then writes the start code to the trigger register. The engine drives chip select low and shifts out the opcode. It then shifts out the buffered bytes and clocks in the response bytes.

Response bytes land in the same buffer, directly behind the bytes that were sent. Software therefore reads the reply at buffer index equal to the transmit count. A busy flag covers the whole frame. Register writes that could disturb a running frame are dropped. A start request whose byte counts do not fit the buffer is refused and leaves a sticky error flag. The SPI link runs in mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. The bit rate comes from a programmable divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sck` is low and the status register (address 0x4A) reads 0. The opcode (0x45), transmit count (0x48) and receive count (0x49) registers read 0. The divider register (0x4B) reads 1.
- R2: A frame shifts out, most significant bit first, the opcode register value and then the transmit-count bytes taken from buffer indices 0 upward. The buffer is addressed on the bus at 0x80 + index, for indices 0 to 71.
- R3: Response byte i, sampled on rising SCK edges after the transmit bytes, is stored at buffer index (transmit count + i). The total number of bytes framed is 1 + transmit count + receive count.
- R4: Status bit 0 (busy) is set on the cycle after a valid start and stays set, with chip select low, until the last response byte is stored and chip select returns high.
- R5: A start whose transmit count plus receive count exceeds 72 is ignored: no frame runs and busy stays 0. It sets status bit 1, the error flag. A sum of exactly 72 is accepted.
- R6: The error flag stays set through later frames. It is cleared only by writing a byte with bit 1 set to the status register.
- R7: While busy is set, writes to the opcode, count, divider and buffer registers leave their contents unchanged.
- R8: SCK high time and low time inside a byte each equal the divider value in system clocks. A divider of 0 acts as 1.
- R9: Chip select goes low at least two divider periods before the first rising SCK edge. It stays low at least one divider period after the final falling edge.
- R10: Only the value 0x01 written to the trigger register (0x47) starts a frame. Any other value has no effect.
- R11: SCK is low whenever chip select is high (mode 0 idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register or buffer byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps every pairing of transmit and receive counts from 0 to 4 under three dividers. It also runs a frame that fills the buffer exactly, and refused frames one byte over the limit and far beyond it in a wide sum. An engine that stored replies from index 0 would overwrite the sent bytes. One that miscounted the boundary would either reject the full buffer or run past it. A model flash returns a position-dependent pattern, so a one-byte slip in the receive window or a wrong bit order shows up as a wrong value at a known index. Writes issued during a running frame are read back afterwards; a design that let them through would change the opcode, counts or buffer contents the bench then sees. Measured SCK pulse widths and chip-select margins expose an off-by-one divider count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [7:0] ADDR_OPCODE  = 8'h45;
  localparam logic [7:0] ADDR_TRIGGER = 8'h47;
  localparam logic [7:0] ADDR_TXCNT   = 8'h48;
  localparam logic [7:0] ADDR_RXCNT   = 8'h49;
  localparam logic [7:0] ADDR_STATUS  = 8'h4A;
  localparam logic [7:0] ADDR_DIV     = 8'h4B;
  localparam logic [7:0] START_CODE   = 8'h01;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_TAIL  = 2'd3
  } seq_state_t;

  // Half-period of SCK in system clocks; zero is promoted to one.
  function automatic logic [7:0] half_period(input logic [7:0] div);
    return (div == 8'd0) ? 8'd1 : div;
  endfunction

  // Sum of both data phases, widened so no count pair can wrap.
  function automatic logic [8:0] phase_sum(input logic [7:0] tx, input logic [7:0] rx);
    return {1'b0, tx} + {1'b0, rx};
  endfunction

  function automatic logic counts_fit(input logic [7:0] tx, input logic [7:0] rx,
                                      input logic [8:0] depth);
    return phase_sum(tx, rx) <= depth;
  endfunction

endpackage

// File: rtl/spi_fifo_ram.sv
module spi_fifo_ram #(
  parameter int DEPTH = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_widx,
  input  logic [7:0] bus_wdata,
  input  logic [7:0] bus_ridx,
  output logic [7:0] bus_rdata,
  input  logic       eng_we,
  input  logic [7:0] eng_widx,
  input  logic [7:0] eng_wdata,
  input  logic [7:0] eng_ridx,
  output logic [7:0] eng_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [8:0] DEPTH_L = 9'(DEPTH);

  logic [7:0] mem [DEPTH];

  wire bus_rd_ok = {1'b0, bus_ridx} < DEPTH_L;
  wire eng_rd_ok = {1'b0, eng_ridx} < DEPTH_L;
  wire bus_wr_ok = {1'b0, bus_widx} < DEPTH_L;
  wire eng_wr_ok = {1'b0, eng_widx} < DEPTH_L;

  always_ff @(posedge clk) begin
    if (eng_we && eng_wr_ok)
      mem[eng_widx[AW-1:0]] <= eng_wdata;
    else if (bus_we && bus_wr_ok)
      mem[bus_widx[AW-1:0]] <= bus_wdata;
  end

  assign bus_rdata = bus_rd_ok ? mem[bus_ridx[AW-1:0]] : 8'h00;
  assign eng_rdata = eng_rd_ok ? mem[eng_ridx[AW-1:0]] : 8'h00;

  // R7
  bus_engine_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !bus_we);

  // R3
  eng_store_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> eng_wr_ok);

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] half,
  output logic       tick
);
  logic [7:0] cnt_q;

  assign tick = run && (cnt_q == half - 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= 8'd0;
    else if (!run || tick) cnt_q <= 8'd0;
    else                   cnt_q <= cnt_q + 8'd1;
  end

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (half == 8'd1));

endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic [7:0] tx_cnt,
  input  logic [7:0] rx_cnt,
  input  logic       tick,
  input  logic       miso,
  output logic [7:0] fifo_ridx,
  input  logic [7:0] fifo_rdata,
  output logic       fifo_we,
  output logic [7:0] fifo_widx,
  output logic [7:0] fifo_wdata,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  output logic       busy
);
  seq_state_t state_q;
  logic [8:0] byte_q;
  logic [2:0] bit_q;
  logic       lead_q;
  logic [7:0] tx_sh_q;
  logic [7:0] rx_sh_q;
  logic       sck_q;

  wire [8:0] last_byte  = phase_sum(tx_cnt, rx_cnt);
  wire       in_shift   = (state_q == SQ_SHIFT);
  wire       rise_evt   = in_shift && tick && !sck_q;
  wire       fall_evt   = in_shift && tick && sck_q;
  wire       byte_done  = fall_evt && (bit_q == 3'd7);
  wire       rx_phase   = byte_q > {1'b0, tx_cnt};
  wire       next_is_tx = byte_q < {1'b0, tx_cnt};
  wire       frame_end  = byte_done && (byte_q == last_byte);

  assign fifo_ridx  = byte_q[7:0];
  assign fifo_widx  = byte_q[7:0] - 8'd1;
  assign fifo_wdata = rx_sh_q;
  assign fifo_we    = byte_done && rx_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      byte_q  <= '0;
      bit_q   <= '0;
      lead_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sck_q   <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          sck_q <= 1'b0;
          if (start) begin
            state_q <= SQ_LEAD;
            byte_q  <= '0;
            bit_q   <= '0;
            lead_q  <= 1'b0;
          end
        end
        SQ_LEAD: begin
          if (tick) begin
            lead_q <= 1'b1;
            if (lead_q) begin
              state_q <= SQ_SHIFT;
              tx_sh_q <= opcode;
            end
          end
        end
        SQ_SHIFT: begin
          if (rise_evt) begin
            sck_q   <= 1'b1;
            rx_sh_q <= {rx_sh_q[6:0], miso};
          end else if (fall_evt) begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (frame_end) begin
                state_q <= SQ_TAIL;
              end else begin
                byte_q  <= byte_q + 9'd1;
                tx_sh_q <= next_is_tx ? fifo_rdata : 8'h00;
              end
            end else begin
              bit_q   <= bit_q + 3'd1;
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
            end
          end
        end
        SQ_TAIL: begin
          if (tick) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign sck  = sck_q;
  assign cs_n = (state_q == SQ_IDLE);
  assign busy = (state_q != SQ_IDLE);
  assign mosi = in_shift ? tx_sh_q[7] : 1'b0;

  // R11
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8
  sck_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck_q));

  // R4
  frame_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> busy && !sck);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int         DEPTH     = 72,
  parameter logic [7:0] FIFO_BASE = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam logic [8:0] DEPTH_L = 9'(DEPTH);

  logic [7:0] opcode_q, txc_q, rxc_q, div_q;
  logic       err_q;
  logic       busy;
  logic       tick;

  wire [7:0] fifo_off = reg_addr - FIFO_BASE;
  wire       fifo_hit = (reg_addr >= FIFO_BASE) && ({1'b0, fifo_off} < DEPTH_L);

  wire wr_ok     = reg_wr && !busy;
  wire trig_wr   = wr_ok && (reg_addr == ADDR_TRIGGER) && (reg_wdata == START_CODE);
  wire fits      = counts_fit(txc_q, rxc_q, DEPTH_L);
  wire trig_go   = trig_wr && fits;
  wire trig_ovf  = trig_wr && !fits;
  wire clr_err   = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[1];
  wire bus_fifo_we = wr_ok && fifo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= 8'h00;
      txc_q    <= 8'h00;
      rxc_q    <= 8'h00;
      div_q    <= 8'h01;
      err_q    <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == ADDR_OPCODE) opcode_q <= reg_wdata;
      if (wr_ok && reg_addr == ADDR_TXCNT)  txc_q    <= reg_wdata;
      if (wr_ok && reg_addr == ADDR_RXCNT)  rxc_q    <= reg_wdata;
      if (wr_ok && reg_addr == ADDR_DIV)    div_q    <= reg_wdata;
      if (trig_ovf)     err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  logic [7:0] eng_ridx, eng_rdata, eng_widx, eng_wdata, bus_fifo_rdata;
  logic       eng_we;

  spi_fifo_ram #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_fifo_we),
    .bus_widx  (fifo_off),
    .bus_wdata (reg_wdata),
    .bus_ridx  (fifo_off),
    .bus_rdata (bus_fifo_rdata),
    .eng_we    (eng_we),
    .eng_widx  (eng_widx),
    .eng_wdata (eng_wdata),
    .eng_ridx  (eng_ridx),
    .eng_rdata (eng_rdata)
  );

  spi_half_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .half  (half_period(div_q)),
    .tick  (tick)
  );

  spi_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (trig_go),
    .opcode     (opcode_q),
    .tx_cnt     (txc_q),
    .rx_cnt     (rxc_q),
    .tick       (tick),
    .miso       (spi_miso),
    .fifo_ridx  (eng_ridx),
    .fifo_rdata (eng_rdata),
    .fifo_we    (eng_we),
    .fifo_widx  (eng_widx),
    .fifo_wdata (eng_wdata),
    .sck        (spi_sck),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .busy       (busy)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (fifo_hit) reg_rdata = bus_fifo_rdata;
    else begin
      case (reg_addr)
        ADDR_OPCODE: reg_rdata = opcode_q;
        ADDR_TXCNT:  reg_rdata = txc_q;
        ADDR_RXCNT:  reg_rdata = rxc_q;
        ADDR_DIV:    reg_rdata = div_q;
        ADDR_STATUS: reg_rdata = {6'd0, err_q, busy};
        default:     reg_rdata = 8'h00;
      endcase
    end
  end

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_go |=> busy);

  // R5
  overflow_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ovf |=> !busy && err_q);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);

  // R7
  opcode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opcode_q) && $stable(txc_q) && $stable(rxc_q) && $stable(div_q));

endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(input int j);
    return 8'((j * 37 + 91) ^ (j >> 2));
  endfunction

  function automatic logic [7:0] txd(input int k, input int seed);
    return 8'(k * 13 + seed);
  endfunction

  // flash model: response stream and captured MOSI bytes
  int sj, sb, mcnt, mbit;
  logic [7:0] mb;
  logic [7:0] mlog [128];
  always @(negedge spi_cs_n) begin
    sj = 0; sb = 0; mcnt = 0; mbit = 0;
    spi_miso = pat(0)[7];
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    sb++;
    if (sb == 8) begin sb = 0; sj++; end
    spi_miso = pat(sj)[7-sb];
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    mb = {mb[6:0], spi_mosi};
    mbit++;
    if (mbit == 8) begin
      if (mcnt < 128) mlog[mcnt] = mb;
      mcnt++; mbit = 0;
    end
  end

  // timing monitor sampled at negedge
  int cyc = 0, t_csf = 0, t_fall = 0, lead = 0, tail = 0, hi_run = 0, lo_run = 0;
  int exp_half = 1;
  logic hi_bad = 1'b0, lo_bad = 1'b0, first = 1'b0, cs_p = 1'b1, sck_p = 1'b0, idle_bad = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (spi_cs_n && spi_sck) idle_bad = 1'b1;
    if (cs_p && !spi_cs_n) begin t_csf = cyc; first = 1'b1; lo_run = 0; end
    if (!sck_p && spi_sck) begin
      if (first) lead = cyc - t_csf;
      else if (lo_run != exp_half && lo_run != 0) lo_bad = 1'b1;
      first = 1'b0;
    end
    if (spi_sck) hi_run++;
    else if (sck_p) begin
      if (hi_run != exp_half) hi_bad = 1'b1;
      hi_run = 0; t_fall = cyc; lo_run = 0;
    end
    if (!spi_sck && !spi_cs_n && !first) lo_run++;
    if (!cs_p && spi_cs_n) tail = cyc - t_fall;
    cs_p = spi_cs_n; sck_p = spi_sck;
  end

  logic wd_hit = 1'b0;
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    wd_hit = 1'b1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(8'h4A, s);
      if (!s[0] || wd_hit) break;
    end
  endtask

  task automatic run_xfer(input int op, input int tx, input int rx, input int dv, input int seed);
    logic [7:0] s, d;
    int h;
    h = (dv == 0) ? 1 : dv;
    exp_half = h; hi_bad = 1'b0; lo_bad = 1'b0;
    wr(8'h4B, 8'(dv));
    wr(8'h45, 8'(op));
    wr(8'h48, 8'(tx));
    wr(8'h49, 8'(rx));
    for (int k = 0; k < tx; k++) wr(8'(8'h80 + k), txd(k, seed));
    wr(8'h47, 8'h01);
    rd(8'h4A, s);
    // R4: busy right after start
    chk(s[0] == 1'b1 && spi_cs_n == 1'b0, "R4 busy after start", int'(s[0]), 1);
    wait_idle();
    @(negedge clk);
    // R3 frame length
    chk(mcnt == 1 + tx + rx, "R3 byte count", mcnt, 1 + tx + rx);
    // R2 opcode first then tx data
    chk(mlog[0] == 8'(op), "R2 opcode", int'(mlog[0]), op);
    for (int k = 0; k < tx; k++)
      chk(mlog[1+k] == txd(k, seed), "R2 tx byte", int'(mlog[1+k]), int'(txd(k, seed)));
    // R3 rx placement
    for (int i = 0; i < rx; i++) begin
      rd(8'(8'h80 + tx + i), d);
      chk(d == pat(1 + tx + i), "R3 rx byte", int'(d), int'(pat(1 + tx + i)));
    end
    // R2 tx bytes survive
    if (tx > 0) begin
      rd(8'h80, d);
      chk(d == txd(0, seed), "R2 tx kept", int'(d), int'(txd(0, seed)));
    end
    // R8 / R9 timing
    chk(!hi_bad && !lo_bad, "R8 sck width", int'(hi_bad) + int'(lo_bad), 0);
    chk(lead >= 2 * h, "R9 cs lead", lead, 2 * h);
    chk(tail >= h, "R9 cs tail", tail, h);
    chk(!idle_bad, "R11 idle sck", int'(idle_bad), 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins", int'(spi_cs_n), 1);
    rd(8'h4A, d); chk(d == 8'h00, "R1 status", int'(d), 0);
    rd(8'h45, d); chk(d == 8'h00, "R1 opcode", int'(d), 0);
    rd(8'h48, d); chk(d == 8'h00, "R1 txcnt", int'(d), 0);
    rd(8'h4B, d); chk(d == 8'h01, "R1 divider", int'(d), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: wrong trigger value
    wr(8'h47, 8'h02);
    rd(8'h4A, d);
    chk(d[0] == 1'b0 && spi_cs_n == 1'b1, "R10 bad trigger", int'(d), 0);

    // sweep of counts and dividers
    for (int dv = 0; dv < 3; dv++)
      for (int tx = 0; tx < 5; tx++)
        for (int rx = 0; rx < 5; rx++)
          if (!wd_hit) run_xfer(8'h0B + tx * 5 + rx, tx, rx, dv, dv * 31 + tx + 7 * rx);

    // R5 full buffer accepted
    run_xfer(8'h9F, 40, 32, 1, 3);
    rd(8'h4A, d); chk(d[1] == 1'b0, "R5 sum equal depth", int'(d[1]), 0);

    // R5 one over
    wr(8'h49, 8'd33);
    wr(8'h47, 8'h01);
    rd(8'h4A, d);
    chk(d == 8'h02 && spi_cs_n == 1'b1, "R5 overflow refused", int'(d), 2);
    // R6 sticky through a frame
    run_xfer(8'h05, 1, 1, 2, 9);
    rd(8'h4A, d); chk(d[1] == 1'b1, "R6 err sticky", int'(d[1]), 1);
    wr(8'h4A, 8'h02);
    rd(8'h4A, d); chk(d == 8'h00, "R6 err cleared", int'(d), 0);
    // R5 wide sum
    wr(8'h48, 8'd200); wr(8'h49, 8'd100); wr(8'h47, 8'h01);
    rd(8'h4A, d); chk(d == 8'h02, "R5 wide overflow", int'(d), 2);
    wr(8'h4A, 8'h02);

    // R7 writes while busy
    wr(8'h4B, 8'd3); wr(8'h45, 8'h3B); wr(8'h48, 8'd2); wr(8'h49, 8'd2);
    wr(8'h80, 8'h11); wr(8'h81, 8'h22);
    wr(8'h47, 8'h01);
    wr(8'h45, 8'hEE); wr(8'h48, 8'd5); wr(8'h49, 8'd7); wr(8'h4B, 8'd9);
    wr(8'h80, 8'hEE); wr(8'h85, 8'hEE);
    wait_idle();
    rd(8'h45, d); chk(d == 8'h3B, "R7 opcode held", int'(d), 'h3B);
    rd(8'h48, d); chk(d == 8'd2, "R7 txcnt held", int'(d), 2);
    rd(8'h49, d); chk(d == 8'd2, "R7 rxcnt held", int'(d), 2);
    rd(8'h4B, d); chk(d == 8'd3, "R7 divider held", int'(d), 3);
    rd(8'h80, d); chk(d == 8'h11, "R7 fifo held", int'(d), 'h11);
    chk(mlog[0] == 8'h3B && mlog[1] == 8'h11 && mlog[2] == 8'h22, "R7 frame intact",
        int'(mlog[1]), 'h11);
    rd(8'h83, d); chk(d == pat(4), "R3 rx after busy writes", int'(d), int'(pat(4)));

    chk(!wd_hit, "watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule